// File: doc/BRIEF.md
# Programmable Periodic Tick Interrupt Generator

This block produces a periodic interrupt for a real-time-clock subsystem. A reference strobe arrives once per period of a 32.768 kHz reference, sampled into the system clock domain. A free-running 15-bit prescaler counts these strobes. Software chooses a power-of-two division of the strobe rate and loads a reload count. Once started, a down-counter steps once per divided pulse. When it expires, it latches a pending flag that drives the interrupt line. It then reloads and keeps running.

Software uses a small write port with four addresses. These cover control, the reload count, write-one-to-clear of the pending flag, and a read port for the pending flag and the live count. The controller has two states. ST_IDLE holds the count frozen. ST_RUN counts down. The transition T_START (ST_IDLE to ST_RUN) is taken on a control write that sets the master enable, raises the tick enable from 0 to 1, and finds a nonzero stored reload. This transition loads the counter. The transition T_STOP (ST_RUN to ST_IDLE) is taken on a control write that clears the master enable, or that keeps it set while dropping the tick enable. T_STOP leaves the count where it stood. A control write with the master enable clear does not update the divider selection.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset the pending flag, the interrupt and the live count are all 0, and the timer is stopped.
- R2: A write to address 1 (reload) is ignored unless the written value is greater than 2. Larger values are stored.
- R3: With N in control bits [7:4], a divided pulse occurs on every reference strobe that brings the number of strobes since reset to a multiple of 2^N.
- R4: A control write (address 0) with bit 0 = 1 and bit 8 going from 0 to 1 starts the timer with the stored reload, but only if that reload is nonzero. Any other control write never starts it.
- R5: A control write with bit 0 = 0 stops the timer. So does a write with bit 0 = 1 and bit 8 going from 1 to 0. While stopped, the live count holds and no expiry happens.
- R6: While running, the count drops by one per divided pulse. A pulse at count 1 sets pending bit 0, raises tick_irq, and reloads the count, so expiries repeat every C pulses for reload C.
- R7: Writing address 2 with bit 0 = 1 clears pending and lowers tick_irq. Writing bit 0 = 0 leaves them unchanged.
- R8: If an expiry and a clear fall in the same cycle, the pending flag ends up set.
- R9: Reading address 3 returns the live down-counter value. Reading address 2 returns the pending flag in bit 0. Other addresses read 0.
- R10: A control write with bit 0 = 1 updates the divider selection. While running with bit 8 kept at 1, this changes the rate without reloading the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | One-cycle strobe per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload, 2 pending clear) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (2 pending, 3 live count) |
| rd_data | output | 16 | Combinational read data |
| tick_irq | output | 1 | Tick interrupt, high while pending |

## Verification
Two events can land in the same cycle: an expiry that sets the pending flag, and a software write that clears it. The bench provokes this by driving a reference strobe and a write-one-to-clear together on the strobe that takes the count from 1 to its reload value. It then expects the flag and the interrupt to remain high. Two further overlaps are also driven on purpose: a clear that coincides with a non-expiring strobe, and a rate change made while counting. In each case the expected count and flag are derived from the number of strobes since reset.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tick_state_e;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_PEND   = 2'd2;
    localparam logic [1:0] A_LIVE   = 2'd3;

    localparam int CTL_MASTER_BIT = 0;
    localparam int CTL_SEL_LSB    = 4;
    localparam int CTL_TICK_BIT   = 8;
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
    parameter int PRE_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb,
    input  logic [SEL_W-1:0] sel,
    output logic             div_pulse
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;

    // free-running strobe counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (ref_stb) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // pulse when the low N bits are about to roll over
    always_comb begin
        low_mask  = ~({PRE_W{1'b1}} << sel);
        div_pulse = ref_stb && ((pre_q & low_mask) == low_mask);
    end
endmodule

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl
    import rtc_tick_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int SEL_W      = 4,
    parameter int RELOAD_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              start_req,
    output logic              stop_req,
    output logic              pend_clr
);
    logic tick_en_q;
    logic ctl_wr;
    logic new_master;
    logic new_tick;
    logic reload_ok;

    always_comb begin
        ctl_wr     = wr_en && (wr_addr == A_CTRL);
        new_master = wr_data[CTL_MASTER_BIT];
        new_tick   = wr_data[CTL_TICK_BIT];
        reload_ok  = wr_en && (wr_addr == A_RELOAD) &&
                     (wr_data > DATA_W'(RELOAD_MIN));
        start_req  = ctl_wr && new_master && new_tick && !tick_en_q &&
                     (reload_q != '0);
        stop_req   = ctl_wr && (!new_master || (!new_tick && tick_en_q));
        pend_clr   = wr_en && (wr_addr == A_PEND) && wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_en_q <= 1'b0;
            sel_q     <= '0;
            reload_q  <= '0;
        end else begin
            if (ctl_wr) begin
                tick_en_q <= new_tick;
                if (new_master) begin
                    sel_q <= wr_data[CTL_SEL_LSB +: SEL_W];
                end
            end
            if (reload_ok) begin
                reload_q <= wr_data[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
    import rtc_tick_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             div_pulse,
    input  logic             pend_clr,
    input  logic [CNT_W-1:0] reload_q,
    output tick_state_e      state_q,
    output logic [CNT_W-1:0] live_cnt,
    output logic             pend_q,
    output logic             expire
);
    tick_state_e      state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             load;
    logic             step;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_START, T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_RUN;
            ST_RUN:  if (stop_req)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath controls and next count
    always_comb begin
        load   = (state_q == ST_IDLE) && start_req;
        step   = (state_q == ST_RUN) && !stop_req && div_pulse;
        expire = step && (live_cnt == CNT_W'(1));
        cnt_d  = live_cnt;
        if (load || expire) begin
            cnt_d = reload_q;
        end else if (step) begin
            cnt_d = live_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
            pend_q   <= 1'b0;
        end else begin
            live_cnt <= cnt_d;
            if (expire) begin
                pend_q <= 1'b1;
            end else if (pend_clr) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
    import rtc_tick_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 15,
    parameter int SEL_W      = 4,
    parameter int RELOAD_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick_irq
);
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] reload_q;
    logic             start_req;
    logic             stop_req;
    logic             pend_clr;
    logic             div_pulse;
    tick_state_e      core_state;
    logic [CNT_W-1:0] live_cnt;
    logic             pend_q;
    logic             expire;

    rtc_tick_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb),
        .sel(sel_q), .div_pulse(div_pulse)
    );

    rtc_tick_ctrl #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .RELOAD_MIN(RELOAD_MIN)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel_q(sel_q), .reload_q(reload_q),
        .start_req(start_req), .stop_req(stop_req), .pend_clr(pend_clr)
    );

    rtc_tick_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .div_pulse(div_pulse), .pend_clr(pend_clr), .reload_q(reload_q),
        .state_q(core_state), .live_cnt(live_cnt), .pend_q(pend_q),
        .expire(expire)
    );

    always_comb begin
        tick_irq = pend_q;
        unique case (rd_addr)
            A_PEND:  rd_data = DATA_W'(pend_q);
            A_LIVE:  rd_data = DATA_W'(live_cnt);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk #(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int RELOAD_MIN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick_irq,
    input logic              is_run,
    input logic              start_req,
    input logic              stop_req,
    input logic              pend_clr,
    input logic              expire,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  live_cnt
);
    p_short_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_data <= DATA_W'(RELOAD_MIN)) |=> $stable(reload_q));

    p_start_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !is_run) |=> (is_run && live_cnt == $past(reload_q)));

    p_zero_reload_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_run && reload_q == '0) |=> !is_run);

    p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run && stop_req) |=> (!is_run && $stable(live_cnt)));

    p_idle_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_run && !start_req) |=> $stable(live_cnt));

    p_run_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_run |-> (live_cnt != '0));

    p_expire_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tick_irq);

    p_clear_lowers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !expire) |=> !tick_irq);

    p_collision_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && expire) |=> tick_irq);

    p_no_raise_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_run && !tick_irq) |=> !tick_irq);
endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .RELOAD_MIN(RELOAD_MIN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_irq(tick_irq),
    .is_run(core_state == rtc_tick_pkg::ST_RUN),
    .start_req(start_req), .stop_req(stop_req), .pend_clr(pend_clr),
    .expire(expire), .reload_q(reload_q), .live_cnt(live_cnt)
);

// File: tb/rtc_tick_timer_tb.sv
module rtc_tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tick_irq;

    int n_chk = 0;
    int n_err = 0;
    int ns_cnt = 0;

    always #5 clk = ~clk;

    rtc_tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tick_irq(tick_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic strobe(input bit with_clr);
        @(negedge clk);
        ref_stb = 1'b1;
        if (with_clr) begin
            wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0001;
        end
        @(negedge clk);
        ref_stb = 1'b0; wr_en = 1'b0;
        ns_cnt++;
    endtask

    // expected divided pulse on the strobe just issued (R3)
    function automatic bit pulse_now(input int n);
        return (ns_cnt % (1 << n)) == 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int v;
        int pulses;
        int exp_live;
        bit fire;
        bit tried_zero;
        tried_zero = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd2, v); check("R1 pending", v, 0);
        reg_rd(2'd3, v); check("R1 live", v, 0);
        check("R1 irq", int'(tick_irq), 0);
        reg_rd(2'd0, v); check("R9 other read", v, 0);

        // R4 no start with zero reload
        reg_wr(2'd0, 16'h0101);
        reg_rd(2'd3, v); check("R4 zero reload live", v, 0);
        for (int i = 0; i < 3; i++) strobe(1'b0);
        reg_rd(2'd2, v); check("R4 zero reload pending", v, 0);
        reg_wr(2'd0, 16'h0001);

        // R2 short reload ignored
        reg_wr(2'd1, 16'd2);
        reg_wr(2'd1, 16'd1);
        reg_wr(2'd0, 16'h0101);
        reg_rd(2'd3, v); check("R2 short reload ignored", v, 0);
        reg_wr(2'd0, 16'h0001);
        reg_wr(2'd1, 16'd3);
        reg_wr(2'd0, 16'h0101);
        reg_rd(2'd3, v); check("R2 reload 3 accepted", v, 3);
        reg_wr(2'd0, 16'h0001);

        // sweep divider and reload: R3 R6 R9 R7
        for (int sel = 0; sel < 4; sel++) begin
            for (int c = 3; c <= 6; c++) begin
                reg_wr(2'd0, 16'h0001);
                reg_wr(2'd1, 16'(c));
                reg_wr(2'd0, 16'(16'h0101 | (sel << 4)));
                pulses = 0;
                reg_rd(2'd3, v); check("R4 start load", v, c);
                for (int k = 0; k < 2 * c * (1 << sel) + 1; k++) begin
                    strobe(1'b0);
                    fire = 1'b0;
                    if (pulse_now(sel)) begin
                        pulses++;
                        fire = (pulses % c) == 0;
                    end
                    reg_rd(2'd3, v); check("R9 R6 live count", v, c - (pulses % c));
                    reg_rd(2'd2, v); check("R3 R6 pending", v, int'(fire));
                    check("R6 irq", int'(tick_irq), int'(fire));
                    if (fire) begin
                        if (!tried_zero) begin
                            tried_zero = 1'b1;
                            reg_wr(2'd2, 16'h0000);
                            reg_rd(2'd2, v); check("R7 write zero no effect", v, 1);
                        end
                        reg_wr(2'd2, 16'h0001);
                        reg_rd(2'd2, v); check("R7 clear pending", v, 0);
                        check("R7 irq low", int'(tick_irq), 0);
                    end
                end
            end
        end

        // R5 stop by master, hold, restart
        reg_wr(2'd0, 16'h0001);
        reg_wr(2'd1, 16'd5);
        reg_wr(2'd0, 16'h0101);
        strobe(1'b0); strobe(1'b0);
        reg_rd(2'd3, v); check("R6 count down", v, 3);
        reg_wr(2'd0, 16'h0000);
        for (int i = 0; i < 4; i++) strobe(1'b0);
        reg_rd(2'd3, v); check("R5 master off holds", v, 3);
        reg_rd(2'd2, v); check("R5 master off no expiry", v, 0);
        reg_wr(2'd0, 16'h0101);
        reg_rd(2'd3, v); check("R4 restart reload", v, 5);
        strobe(1'b0);
        reg_wr(2'd0, 16'h0001);
        for (int i = 0; i < 3; i++) strobe(1'b0);
        reg_rd(2'd3, v); check("R5 tick off holds", v, 4);

        // R4 no rising edge: master off with tick bit kept, then re-enable
        reg_wr(2'd0, 16'h0101);
        reg_wr(2'd0, 16'h0100);
        strobe(1'b0);
        reg_rd(2'd3, v); check("R5 master cleared holds", v, 5);
        reg_wr(2'd0, 16'h0101);
        strobe(1'b0);
        reg_rd(2'd3, v); check("R4 no rise no start", v, 5);
        reg_wr(2'd0, 16'h0001);

        // R10 rate change while running
        reg_wr(2'd1, 16'd3);
        reg_wr(2'd0, 16'h0101);
        strobe(1'b0);
        reg_rd(2'd3, v); check("R10 before change", v, 2);
        reg_wr(2'd0, 16'h0121);
        reg_rd(2'd3, v); check("R10 no reload on change", v, 2);
        exp_live = 2;
        for (int i = 0; i < 4; i++) begin
            strobe(1'b0);
            if (pulse_now(2)) exp_live--;
            reg_rd(2'd3, v); check("R10 slowed rate", v, exp_live);
        end
        reg_wr(2'd0, 16'h0001);

        // R8 expiry and clear in the same cycle
        reg_wr(2'd0, 16'h0101);
        strobe(1'b0); strobe(1'b0);
        reg_rd(2'd3, v); check("R6 at one", v, 1);
        strobe(1'b1);
        reg_rd(2'd2, v); check("R8 set wins", v, 1);
        check("R8 irq", int'(tick_irq), 1);
        reg_rd(2'd3, v); check("R6 reload after expiry", v, 3);
        strobe(1'b1);
        reg_rd(2'd2, v); check("R7 clear with plain strobe", v, 0);
        reg_rd(2'd3, v); check("R6 continues", v, 2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule